// File: doc/BRIEF.md
# Extended-Precision Accumulator Adder with Flags

This block is the add stage of a fractional two's-complement DSP datapath. It holds two 56-bit accumulators. Each accumulator is built from an 8-bit guard extension on top, a 24-bit upper part and a 24-bit lower part. On a start strobe the block takes a source operand, brings it to 56 bits and adds it into the chosen accumulator. The sum replaces that accumulator and a set of condition flags is updated with it.

The source can be one of three kinds. A 24-bit word is treated as a fraction: it lands in the upper 24-bit part, with zeros below it and sign bits above it. A 48-bit long word is sign-extended from its bit 47. The other accumulator is taken whole. The add completes two clock edges after the strobe is accepted. While an add is in flight the block ignores new strobes.

The flag set is:
- carry out of bit 55
- signed overflow
- zero
- negative
- unnormalized
- extension in use
- a sticky limit flag that stays set until a clear input or reset

Top module: `ext_acc_adder`

## Requirements
- R1: With `src_kind` = 2'b00 the source is `src_data[23:0]`. It is placed at accumulator bits 47:24, with bits 23:0 zero and bits 55:48 copies of `src_data[23]`.
- R2: With `src_kind` = 2'b01 the source is `src_data[47:0]`, sign-extended from bit 47 to 56 bits.
- R3: With `src_kind[1]` = 1 the source is the whole accumulator not chosen by `dst_sel`. It is added without change.
- R4: `dst_sel` = 0 chooses accumulator A (`acc_a`) and 1 chooses accumulator B (`acc_b`). Only the chosen accumulator takes the 56-bit sum, modulo 2^56. The other accumulator keeps its value.
- R5: A start sampled at an edge while `busy` is low makes `busy` high for exactly one cycle. At the next edge the result and flags are written, and `done` is high for exactly that one following cycle.
- R6: A start sampled while `busy` is high is ignored. It produces no further `done` pulse and changes no accumulator.
- R7: `flag_n` equals bit 55 of the result. `flag_z` is 1 exactly when all 56 result bits are zero.
- R8: `flag_c` is the carry out of bit 55 of the unsigned 56-bit add. `flag_v` is 1 when both operands have the same bit 55 and the result's bit 55 differs from it.
- R9: `flag_l` is set by any add that overflows (as in R8) and then stays set. It is cleared one edge after `clr_limit` is sampled high, unless an overflowing add is written at that same edge.
- R10: `flag_e` is 1 when result bits 55 down to 47 are not all equal.
- R11: `flag_u` is 1 when result bits 47 and 46 are equal.
- R12: A synchronous reset clears both accumulators and all flags, and drives `busy` and `done` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe for one add |
| src_kind | input | 2 | Source kind: 00 word, 01 long word, 1x other accumulator |
| src_data | input | 48 | Source value (word in bits 23:0) |
| dst_sel | input | 1 | Destination accumulator: 0 = A, 1 = B |
| clr_limit | input | 1 | Clears the sticky limit flag |
| acc_a | output | 56 | Accumulator A |
| acc_b | output | 56 | Accumulator B |
| busy | output | 1 | Add in flight |
| done | output | 1 | One-cycle pulse when result and flags are written |
| flag_c | output | 1 | Carry out of bit 55 |
| flag_v | output | 1 | Signed overflow |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result bit 55 |
| flag_u | output | 1 | Result unnormalized |
| flag_e | output | 1 | Extension bits in use |
| flag_l | output | 1 | Sticky limit flag |

## Verification
The worked fraction case covers word alignment: adding word 0x000100 and then 0xFFFFFF must leave 0x00_0000FF_000000. A value at the least significant end would expose any misplacement of the word. A long word and then its negation must give zero with a carry out, which separates Z and C from N. Adding the two accumulators into each other in turn makes them grow until bit 55 wraps. This forces V and then shows that L stays set through a later add without overflow, until the clear input takes it down. A start held across the busy cycle tells a design that ignores it apart from one that starts a second add. Random words, long words and accumulator sources, sent to either destination, then cover every flag against a bench model.

// File: rtl/ext_acc_pkg.sv
package ext_acc_pkg;
  typedef enum logic [1:0] {
    SRC_WORD    = 2'b00,
    SRC_LONG    = 2'b01,
    SRC_ACC     = 2'b10,
    SRC_ACC_ALT = 2'b11
  } src_kind_e;

  typedef struct packed {
    logic e;
    logic u;
    logic n;
    logic z;
    logic v;
    logic c;
  } arith_flags_t;
endpackage

// File: rtl/ext_acc_src_align.sv
module ext_acc_src_align #(
  parameter int unsigned EXT_W  = 8,
  parameter int unsigned PART_W = 24
) (
  input  logic [1:0]                    kind,
  input  logic [2*PART_W-1:0]           data,
  input  logic [EXT_W+2*PART_W-1:0]     other_acc,
  output logic [EXT_W+2*PART_W-1:0]     aligned
);
  import ext_acc_pkg::*;
  localparam int unsigned ACC_W  = EXT_W + 2*PART_W;
  localparam int unsigned LONG_W = 2*PART_W;

  // word sits in the upper part: zeros below, sign copies above
  function automatic logic [ACC_W-1:0] place_word(input logic [PART_W-1:0] w);
    return {{EXT_W{w[PART_W-1]}}, w, {PART_W{1'b0}}};
  endfunction

  function automatic logic [ACC_W-1:0] place_long(input logic [LONG_W-1:0] d);
    return {{EXT_W{d[LONG_W-1]}}, d};
  endfunction

  always_comb begin
    unique case (src_kind_e'(kind))
      SRC_WORD: aligned = place_word(data[PART_W-1:0]);
      SRC_LONG: aligned = place_long(data);
      default:  aligned = other_acc;
    endcase
  end
endmodule

// File: rtl/ext_acc_sum_flags.sv
module ext_acc_sum_flags #(
  parameter int unsigned EXT_W  = 8,
  parameter int unsigned PART_W = 24
) (
  input  logic [EXT_W+2*PART_W-1:0] addend_a,
  input  logic [EXT_W+2*PART_W-1:0] addend_b,
  output logic [EXT_W+2*PART_W-1:0] sum,
  output ext_acc_pkg::arith_flags_t flags
);
  import ext_acc_pkg::*;
  localparam int unsigned ACC_W  = EXT_W + 2*PART_W;
  localparam int unsigned TOP    = ACC_W - 1;
  localparam int unsigned NORM   = 2*PART_W - 1;
  localparam int unsigned EXTN_W = EXT_W + 1;

  function automatic logic [ACC_W:0] wide_add(input logic [ACC_W-1:0] a,
                                              input logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  function automatic logic signed_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  function automatic logic ext_in_use(input logic [EXTN_W-1:0] s);
    return !((&s) || !(|s));
  endfunction

  logic [ACC_W:0] raw;

  always_comb begin
    raw     = wide_add(addend_a, addend_b);
    sum     = raw[ACC_W-1:0];
    flags.c = raw[ACC_W];
    flags.v = signed_ovf(addend_a[TOP], addend_b[TOP], raw[TOP]);
    flags.n = raw[TOP];
    flags.z = (raw[ACC_W-1:0] == '0);
    flags.e = ext_in_use(raw[TOP:NORM]);
    flags.u = (raw[NORM] == raw[NORM-1]);
  end
endmodule

// File: rtl/ext_acc_adder.sv
module ext_acc_adder #(
  parameter int unsigned EXT_W  = 8,
  parameter int unsigned PART_W = 24
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [1:0]                    src_kind,
  input  logic [2*PART_W-1:0]           src_data,
  input  logic                          dst_sel,
  input  logic                          clr_limit,
  output logic [EXT_W+2*PART_W-1:0]     acc_a,
  output logic [EXT_W+2*PART_W-1:0]     acc_b,
  output logic                          busy,
  output logic                          done,
  output logic                          flag_c,
  output logic                          flag_v,
  output logic                          flag_z,
  output logic                          flag_n,
  output logic                          flag_u,
  output logic                          flag_e,
  output logic                          flag_l
);
  import ext_acc_pkg::*;
  localparam int unsigned ACC_W = EXT_W + 2*PART_W;
  localparam int unsigned N_ACC = 2;

  logic [ACC_W-1:0] acc_q [N_ACC];
  logic [ACC_W-1:0] op_q;
  logic             dst_q;
  logic             busy_q;
  logic             done_q;
  arith_flags_t     flags_q;
  logic             flag_l_q;

  // named internal events
  logic             accept;
  logic             wr_en;
  logic [ACC_W-1:0] aligned;
  logic [ACC_W-1:0] sum;
  arith_flags_t     sum_flags;
  logic             ovf;

  assign accept = start && !busy_q;
  assign wr_en  = busy_q;
  assign ovf    = sum_flags.v;

  ext_acc_src_align #(.EXT_W(EXT_W), .PART_W(PART_W)) u_align (
    .kind      (src_kind),
    .data      (src_data),
    .other_acc (acc_q[~dst_sel]),
    .aligned   (aligned)
  );

  ext_acc_sum_flags #(.EXT_W(EXT_W), .PART_W(PART_W)) u_sum (
    .addend_a (acc_q[dst_q]),
    .addend_b (op_q),
    .sum      (sum),
    .flags    (sum_flags)
  );

  // stage 1: capture operand
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= '0;
      dst_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      busy_q <= accept;
      if (accept) begin
        op_q  <= aligned;
        dst_q <= dst_sel;
      end
    end
  end

  // stage 2: write result and flags
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ACC; i++) acc_q[i] <= '0;
      flags_q  <= '0;
      flag_l_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= wr_en;
      if (wr_en) begin
        for (int i = 0; i < N_ACC; i++)
          if (dst_q == i[0]) acc_q[i] <= sum;
        flags_q <= sum_flags;
      end
      flag_l_q <= (flag_l_q && !clr_limit) || (wr_en && ovf);
    end
  end

  assign acc_a  = acc_q[0];
  assign acc_b  = acc_q[1];
  assign busy   = busy_q;
  assign done   = done_q;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;
  assign flag_z = flags_q.z;
  assign flag_n = flags_q.n;
  assign flag_u = flags_q.u;
  assign flag_e = flags_q.e;
  assign flag_l = flag_l_q;

  assert_busy_then_done_R5: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> done_q);
  assert_done_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> !busy_q);
  assert_other_acc_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !dst_q) |=> (acc_q[1] == $past(acc_q[1])));
  assert_other_acc_kept_b_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && dst_q) |=> (acc_q[0] == $past(acc_q[0])));
  assert_n_tracks_R7: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (flags_q.n == acc_q[dst_q][ACC_W-1]));
  assert_limit_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (flag_l_q && !clr_limit) |=> flag_l_q);
  assert_limit_on_ovf_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && ovf) |=> flag_l_q);
endmodule

// File: tb/ext_acc_adder_bench.sv
module ext_acc_adder_bench;
  logic        clk = 1'b0;
  logic        rst, start, dst_sel, clr_limit;
  logic [1:0]  src_kind;
  logic [47:0] src_data;
  logic [55:0] acc_a, acc_b;
  logic busy, done, flag_c, flag_v, flag_z, flag_n, flag_u, flag_e, flag_l;

  int total = 0;
  int bad = 0;

  logic [55:0] m_acc [2];
  logic m_c, m_v, m_z, m_n, m_u, m_e, m_l;

  always #2 clk = ~clk;

  ext_acc_adder u_ext_acc_adder (
    .clk(clk), .rst(rst), .start(start), .src_kind(src_kind), .src_data(src_data),
    .dst_sel(dst_sel), .clr_limit(clr_limit), .acc_a(acc_a), .acc_b(acc_b),
    .busy(busy), .done(done), .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z),
    .flag_n(flag_n), .flag_u(flag_u), .flag_e(flag_e), .flag_l(flag_l)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // source value restated with signed arithmetic
  function automatic logic [55:0] src_val(input logic [1:0] k, input logic [47:0] d,
                                          input logic [55:0] other);
    logic signed [55:0] v;
    if (k == 2'b00) begin
      v = 56'($signed(d[23:0]));
      v = v * 56'sd16777216;
    end else if (k == 2'b01) begin
      v = 56'($signed(d));
    end else begin
      v = other;
    end
    return v;
  endfunction

  task automatic model_add(input logic [1:0] k, input logic [47:0] d, input logic dst);
    logic [56:0] s;
    logic [55:0] a, b, r;
    a = m_acc[dst];
    b = src_val(k, d, m_acc[~dst]);
    s = {1'b0, a} + {1'b0, b};
    r = s[55:0];
    m_c = s[56];
    m_v = (a[55] == b[55]) && (r[55] != a[55]);
    m_n = r[55];
    m_z = (r == 56'd0);
    m_e = !(r[55:47] == 9'h1FF || r[55:47] == 9'h000);
    m_u = (r[47] == r[46]);
    m_l = m_l | m_v;
    m_acc[dst] = r;
  endtask

  task automatic check_state(input string tag);
    chk({"R4 acc_a ", tag}, 64'(acc_a), 64'(m_acc[0]));
    chk({"R4 acc_b ", tag}, 64'(acc_b), 64'(m_acc[1]));
    chk({"R8 flag_c ", tag}, 64'(flag_c), 64'(m_c));
    chk({"R8 flag_v ", tag}, 64'(flag_v), 64'(m_v));
    chk({"R7 flag_z ", tag}, 64'(flag_z), 64'(m_z));
    chk({"R7 flag_n ", tag}, 64'(flag_n), 64'(m_n));
    chk({"R11 flag_u ", tag}, 64'(flag_u), 64'(m_u));
    chk({"R10 flag_e ", tag}, 64'(flag_e), 64'(m_e));
    chk({"R9 flag_l ", tag}, 64'(flag_l), 64'(m_l));
  endtask

  task automatic do_add(input logic [1:0] k, input logic [47:0] d, input logic dst,
                        input bit hold, input string tag);
    @(negedge clk);
    start = 1'b1; src_kind = k; src_data = d; dst_sel = dst;
    model_add(k, d, dst);
    @(negedge clk);
    chk({"R5 busy ", tag}, 64'(busy), 64'd1);
    chk({"R5 done early ", tag}, 64'(done), 64'd0);
    if (hold) begin
      src_kind = 2'b01; src_data = 48'h123456_789ABC; dst_sel = ~dst;
    end else begin
      start = 1'b0;
    end
    @(negedge clk);
    start = 1'b0;
    chk({"R5 done ", tag}, 64'(done), 64'd1);
    check_state(tag);
    if (hold) begin
      @(negedge clk);
      chk({"R6 done ", tag}, 64'(done), 64'd0);
      chk({"R6 busy ", tag}, 64'(busy), 64'd0);
      chk({"R6 acc_a ", tag}, 64'(acc_a), 64'(m_acc[0]));
      chk({"R6 acc_b ", tag}, 64'(acc_b), 64'(m_acc[1]));
    end
  endtask

  task automatic clear_limit();
    @(negedge clk);
    clr_limit = 1'b1;
    @(negedge clk);
    clr_limit = 1'b0;
    m_l = 1'b0;
    chk("R9 flag_l cleared", 64'(flag_l), 64'd0);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    rst = 1'b1; start = 1'b0; dst_sel = 1'b0; clr_limit = 1'b0;
    src_kind = 2'b00; src_data = '0;
    m_acc[0] = '0; m_acc[1] = '0;
    {m_c, m_v, m_z, m_n, m_u, m_e, m_l} = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R12 reset state
    chk("R12 acc_a", 64'(acc_a), 64'd0);
    chk("R12 acc_b", 64'(acc_b), 64'd0);
    chk("R12 busy", 64'(busy), 64'd0);
    chk("R12 done", 64'(done), 64'd0);
    chk("R12 flags", 64'({flag_c, flag_v, flag_z, flag_n, flag_u, flag_e, flag_l}), 64'd0);

    // R1 word placed in upper part
    do_add(2'b00, 48'h000000_000100, 1'b0, 1'b0, "R1 word");
    chk("R1 word result", 64'(acc_a), 64'h00_000100_000000);
    do_add(2'b00, 48'h000000_FFFFFF, 1'b0, 1'b0, "R1 neg word");
    chk("R1 neg word result", 64'(acc_a), 64'h00_0000FF_000000);

    // R2 long sign-extended into B
    do_add(2'b01, 48'h800000_000001, 1'b1, 1'b0, "R2 long");
    chk("R2 long result", 64'(acc_b), 64'hFF_800000_000001);

    // R3 other accumulator as source
    do_add(2'b10, 48'h0, 1'b0, 1'b0, "R3 acc src");
    chk("R3 acc src result", 64'(acc_a), 64'hFF_8000FF_000001);

    // R7/R8 zero with carry
    do_add(2'b01, 48'h000000_000005, 1'b1, 1'b0, "R7 pre");
    do_add(2'b01, 48'h7FFFFF_FFFFFF - 48'h800000_000001 + 48'h1, 1'b1, 1'b0, "R7 cancel");
    do_add(2'b01, 48'hFFFFFF_FFFFFB - 48'h7FFFFF_FFFFFF - 48'h1, 1'b1, 1'b0, "R7 zero");
    chk("R7 zero acc_b", 64'(acc_b), 64'(m_acc[1]));

    // R8/R9 overflow by alternate growth
    clear_limit();
    do_add(2'b01, 48'h400000_000000, 1'b1, 1'b0, "R9 seed");
    for (int i = 0; i < 40 && !m_l; i++) begin
      do_add(2'b10, 48'h0, 1'b0, 1'b0, "R9 grow a");
      if (!m_l) do_add(2'b10, 48'h0, 1'b1, 1'b0, "R9 grow b");
    end
    chk("R9 overflow seen", 64'(flag_l), 64'd1);
    do_add(2'b00, 48'h0, 1'b0, 1'b0, "R9 no-ovf add");
    chk("R9 sticky after no-ovf", 64'(flag_l), 64'd1);
    clear_limit();

    // R6 start held during busy
    do_add(2'b00, 48'h000000_400000, 1'b0, 1'b1, "R6 held start");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [1:0]  k;
      logic [47:0] d;
      k = 2'($urandom());
      d = {$urandom(), $urandom()};
      if (i % 5 == 0) d = 48'h0;
      do_add(k, d, 1'($urandom()), (i % 37) == 3, "random");
      if ((i % 29) == 0) clear_limit();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule